// File: doc/BRIEF.md
# Bus Master Timeout Request Masker

This block sits in front of a five-way bus arbiter, with four external request/grant pairs and one internal pair. It watches each master that holds the bus grant. When the bus goes idle, the granted master should start a transaction. If it does not, the block counts the clocks. A granted master that keeps requesting but never produces an address phase within the timeout window is judged broken. From then on, its request line is held off before the arbiter sees it, so arbitration moves on to the other requestors.

Each master has one sticky fault flag, which tells the host which masters were cut off. The host clears chosen flags with a one-cycle strobe and a per-master bit select. Clearing a flag also lifts that master's mask.

The frame signal used for detection depends on who owns the bus. When the internal master holds the grant, the internal frame is used. Otherwise the external bus frame is used. Bit 0 of every per-master vector is the internal master, and every signal is active high.

Top module: `tmm_req_masker`

## Requirements
- R1: While `rst_n` is low, `req_out` and `fault` are all zero, whatever the request inputs are. On the first cycle after release they are still zero.
- R2: `req_out` is the raw request vector with flagged masters removed (`req_raw & ~fault`), registered once. A change on `req_raw` appears on `req_out` one clock edge later.
- R3: The timeout count starts only on a clock where the bus is idle, meaning the selected frame and `irdy_q` are both low.
  - If the granted master keeps requesting, holds the grant alone and makes no address phase, its `fault` bit rises on the 17th rising edge. The edge that samples the first idle cycle counts as edge one.
  - While `irdy_q` is high, no count runs.
- R4: An address phase ends the count without a fault. An address phase is a cycle where the selected frame is high after being low on the previous cycle.
- R5: When grant bit 0 (the internal master) is set, only `frame_int` is used as the frame. With any other owner, only `frame_ext` is used.
- R6: A change of the grant vector, or a drop of the granted master's request, discards the count in progress. Counting then begins again from the next idle cycle.
- R7: A flagged master's request never reaches `req_out`. A flagged master is not counted again while its flag is set.
- R8: A cycle with `clr_stb` high clears every fault bit selected in `clr_sel`. Flags not selected are kept. `clr_sel` has no effect without `clr_stb`.
- R9: A fault bit can only rise for the master that holds the grant, and only while exactly one grant bit is set. At most one fault bit rises on any clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_raw | input | N_MASTERS | Raw request per master, bit 0 internal |
| gnt | input | N_MASTERS | Current grant vector from the arbiter, one-hot when valid |
| frame_ext | input | 1 | Latched external bus frame, active high |
| frame_int | input | 1 | Frame of the internal master, active high |
| irdy_q | input | 1 | Latched initiator-ready, active high |
| clr_stb | input | 1 | One-cycle host clear strobe |
| clr_sel | input | N_MASTERS | Per-master select for the clear strobe |
| req_out | output | N_MASTERS | Registered, filtered request vector toward the arbiter |
| fault | output | N_MASTERS | Sticky per-master timeout flags, also the request masks |

## Verification
The bench builds the block with five masters, the internal one at index 0, a timeout of 16 clocks and the frame-source selection turned on. With these values the whole 17-edge window is short enough to run to completion many times. Each run lands exactly on the edge where the flag must rise, and the edge before it is checked as well.

The internal/external frame choice can be exercised in both directions, as can a grant hand-over and a request drop in the middle of a count. Every master index, including the internal one, can be flagged and then cleared selectively.

// File: rtl/tmm_pkg.sv
package tmm_pkg;

   // Watch state of the dead-grant detector
   typedef enum logic [0:0] {
      WD_WAIT_IDLE = 1'b0,
      WD_COUNT     = 1'b1
   } wd_state_e;

endpackage

// File: rtl/tmm_bus_phase.sv
// Picks the frame source from the bus owner and derives idle / address phase.
module tmm_bus_phase #(
   parameter bit USE_INT_FRAME = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic int_owner,
   input  logic frame_ext,
   input  logic frame_int,
   input  logic irdy_q,
   output logic bus_idle,
   output logic addr_phase
);

   logic frame_sel;
   logic frame_prev;

   generate
      if (USE_INT_FRAME) begin : g_owner_frame
         assign frame_sel = int_owner ? frame_int : frame_ext;
      end else begin : g_ext_frame
         logic unused_int_path;
         assign unused_int_path = int_owner ^ frame_int;
         assign frame_sel = frame_ext;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) frame_prev <= 1'b0;
      else        frame_prev <= frame_sel;
   end

   assign bus_idle   = ~frame_sel & ~irdy_q;
   assign addr_phase = frame_sel & ~frame_prev;

endmodule

// File: rtl/tmm_watchdog.sv
// Counts dead-grant clocks after the bus went idle; emits a one-hot trip.
module tmm_watchdog
   import tmm_pkg::*;
#(
   parameter int N       = 5,
   parameter int TIMEOUT = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] gnt,
   input  logic [N-1:0] req_live,
   input  logic         bus_idle,
   input  logic         addr_phase,
   output logic [N-1:0] trip
);

   localparam int                CNT_W    = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
   localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(TIMEOUT - 1);
   localparam logic [N-1:0]      ONE      = {{(N-1){1'b0}}, 1'b1};

   wd_state_e        state;
   logic [CNT_W-1:0] cnt;
   logic [N-1:0]     gnt_prev;
   logic             single_gnt;
   logic             live;
   logic             restart;
   logic             fire;

   assign single_gnt = (gnt != '0) && ((gnt & (gnt - ONE)) == '0);
   assign live       = single_gnt && ((gnt & req_live) != '0);
   assign restart    = (gnt != gnt_prev) || !live;
   assign fire       = (state == WD_COUNT) && !restart && !addr_phase
                       && (cnt == CNT_LAST);
   assign trip       = fire ? gnt : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_prev <= '0;
         state    <= WD_WAIT_IDLE;
         cnt      <= '0;
      end else begin
         gnt_prev <= gnt;
         if (restart) begin
            state <= WD_WAIT_IDLE;
            cnt   <= '0;
         end else begin
            case (state)
               WD_WAIT_IDLE: begin
                  cnt <= '0;
                  if (bus_idle) state <= WD_COUNT;
               end
               WD_COUNT: begin
                  if (addr_phase || fire) begin
                     state <= WD_WAIT_IDLE;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: begin
                  state <= WD_WAIT_IDLE;
                  cnt   <= '0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/tmm_flag_bank.sv
// Sticky per-master fault flags; a trip sets, a strobed select clears.
module tmm_flag_bank #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] trip,
   input  logic         clr_stb,
   input  logic [N-1:0] clr_sel,
   output logic [N-1:0] flags
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       flag_q <= 1'b0;
            else if (trip[i])                 flag_q <= 1'b1;
            else if (clr_stb && clr_sel[i])   flag_q <= 1'b0;
         end
         assign flags[i] = flag_q;
      end
   endgenerate

endmodule

// File: rtl/tmm_req_masker.sv
module tmm_req_masker #(
   parameter int N_MASTERS     = 5,
   parameter int INT_IDX       = 0,
   parameter int TIMEOUT       = 16,
   parameter bit USE_INT_FRAME = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_MASTERS-1:0] req_raw,
   input  logic [N_MASTERS-1:0] gnt,
   input  logic                 frame_ext,
   input  logic                 frame_int,
   input  logic                 irdy_q,
   input  logic                 clr_stb,
   input  logic [N_MASTERS-1:0] clr_sel,
   output logic [N_MASTERS-1:0] req_out,
   output logic [N_MASTERS-1:0] fault
);

   generate
      if (N_MASTERS < 2) begin : g_bad_count
         $error("tmm_req_masker: N_MASTERS must be at least 2");
      end
      if (INT_IDX < 0 || INT_IDX >= N_MASTERS) begin : g_bad_int
         $error("tmm_req_masker: INT_IDX out of range");
      end
      if (TIMEOUT < 2) begin : g_bad_timeout
         $error("tmm_req_masker: TIMEOUT must be at least 2");
      end
   endgenerate

   logic                 bus_idle;
   logic                 addr_phase;
   logic [N_MASTERS-1:0] trip;
   logic [N_MASTERS-1:0] req_live;
   logic [N_MASTERS-1:0] req_out_q;

   assign req_live = req_raw & ~fault;

   tmm_bus_phase #(
      .USE_INT_FRAME(USE_INT_FRAME)
   ) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .int_owner  (gnt[INT_IDX]),
      .frame_ext  (frame_ext),
      .frame_int  (frame_int),
      .irdy_q     (irdy_q),
      .bus_idle   (bus_idle),
      .addr_phase (addr_phase)
   );

   tmm_watchdog #(
      .N       (N_MASTERS),
      .TIMEOUT (TIMEOUT)
   ) u_wd (
      .clk        (clk),
      .rst_n      (rst_n),
      .gnt        (gnt),
      .req_live   (req_live),
      .bus_idle   (bus_idle),
      .addr_phase (addr_phase),
      .trip       (trip)
   );

   tmm_flag_bank #(
      .N (N_MASTERS)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .trip    (trip),
      .clr_stb (clr_stb),
      .clr_sel (clr_sel),
      .flags   (fault)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_out_q <= '0;
      else        req_out_q <= req_live;
   end

   assign req_out = req_out_q;

endmodule

// File: rtl/tmm_req_masker_chk.sv
module tmm_req_masker_chk #(
   parameter int N_MASTERS = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [N_MASTERS-1:0] req_raw,
   input logic [N_MASTERS-1:0] gnt,
   input logic                 clr_stb,
   input logic [N_MASTERS-1:0] clr_sel,
   input logic [N_MASTERS-1:0] req_out,
   input logic [N_MASTERS-1:0] fault
);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assert_filter_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (req_out == ($past(req_raw) & ~$past(fault))));

   assert_flagged_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> ((req_out & $past(fault)) == '0));

   assert_flag_only_granted_R9: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> ((fault & ~$past(fault) & ~$past(gnt)) == '0));

   assert_one_new_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> ($countones(fault & ~$past(fault)) <= 1));

   assert_clear_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> ((~fault & $past(fault)
                    & ~($past(clr_sel) & {N_MASTERS{$past(clr_stb)}})) == '0));

endmodule

bind tmm_req_masker tmm_req_masker_chk #(.N_MASTERS(N_MASTERS)) u_chk (.*);

// File: tb/tb_tmm_req_masker.sv
module tb_tmm_req_masker;

   localparam int CLK_PERIOD = 10;
   localparam int N = 5;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [N-1:0] req_raw, gnt, clr_sel, req_out, fault;
   logic         frame_ext, frame_int, irdy_q, clr_stb;
   int           cyc = 0;
   int           checks = 0;
   int           failures = 0;
   bit           done = 1'b0;

   typedef struct {
      int           at;
      logic [N-1:0] rq;
      logic [N-1:0] fl;
      bit           chk_rq;
      string        tag;
   } exp_t;

   exp_t sb[$];

   tmm_req_masker dut (
      .clk(clk), .rst_n(rst_n), .req_raw(req_raw), .gnt(gnt),
      .frame_ext(frame_ext), .frame_int(frame_int), .irdy_q(irdy_q),
      .clr_stb(clr_stb), .clr_sel(clr_sel), .req_out(req_out), .fault(fault)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic expect_at(int at, logic [N-1:0] rq, logic [N-1:0] fl,
                            bit chk_rq, string tag);
      exp_t e;
      int   i = 0;
      e.at = at; e.rq = rq; e.fl = fl; e.chk_rq = chk_rq; e.tag = tag;
      while (i < sb.size() && sb[i].at <= at) i++;
      sb.insert(i, e);
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   // Monitor: pops expected items as their cycle is reached
   always @(posedge clk) begin
      exp_t e;
      #(CLK_PERIOD/4);
      while (sb.size() > 0 && sb[0].at <= cyc) begin
         e = sb.pop_front();
         checks++;
         if (e.at < cyc) begin
            failures++;
            $display("FAIL %s: sample missed at cycle %0d (actual cycle %0d)", e.tag, e.at, cyc);
         end else if (fault !== e.fl || (e.chk_rq && req_out !== e.rq)) begin
            failures++;
            $display("FAIL %s: actual req_out=%b fault=%b expected req_out=%b fault=%b",
                     e.tag, req_out, fault, e.rq, e.fl);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not finish, actual pending=%0d expected 0", sb.size());
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int c;
      rst_n = 1'b0; req_raw = 5'b11111; gnt = '0; clr_stb = 1'b0; clr_sel = '0;
      frame_ext = 1'b1; frame_int = 1'b1; irdy_q = 1'b0;

      // R1: reset state
      tick(1);
      expect_at(cyc + 2, 5'b00000, 5'b00000, 1, "R1 outputs zero in reset");
      tick(4);
      rst_n = 1'b1; req_raw = '0;
      expect_at(cyc + 1, 5'b00000, 5'b00000, 1, "R1 outputs zero after release");

      // R2: registered filter, one cycle
      tick(2);
      c = cyc; req_raw = 5'b10110;
      expect_at(c + 1, 5'b10110, 5'b00000, 1, "R2 request after one edge");
      tick(1); req_raw = 5'b01001;
      expect_at(c + 2, 5'b01001, 5'b00000, 1, "R2 next pattern");

      // R3: timeout on external master 2
      tick(1); gnt = 5'b00100; req_raw = 5'b00100;
      tick(2); c = cyc; frame_ext = 1'b0;
      expect_at(c + 16, 5'b00100, 5'b00000, 1, "R3 no fault before window end");
      expect_at(c + 17, 5'b00100, 5'b00100, 1, "R3 fault after idle window");
      expect_at(c + 18, 5'b00000, 5'b00100, 1, "R7 flagged request blocked");
      tick(19); gnt = '0; frame_ext = 1'b1;

      // R4: address phase ends the count
      tick(1); gnt = 5'b01000; req_raw = 5'b01100;
      tick(2); c = cyc; frame_ext = 1'b0;
      tick(5); frame_ext = 1'b1;
      expect_at(c + 25, 5'b01000, 5'b00100, 1, "R4 address phase avoids fault");
      tick(25); gnt = '0;

      // R3: irdy high blocks idle
      tick(1); gnt = 5'b10000; req_raw = 5'b11100; frame_ext = 1'b0; irdy_q = 1'b1;
      tick(20); c = cyc;
      expect_at(c + 1, 5'b11000, 5'b00100, 1, "R3 irdy high keeps count stopped");
      irdy_q = 1'b0;
      expect_at(c + 17, 5'b11000, 5'b10100, 1, "R3 fault once frame and irdy low");
      expect_at(c + 18, 5'b01000, 5'b10100, 1, "R7 master 4 blocked");
      tick(19); gnt = '0; frame_ext = 1'b1;

      // R5: internal owner uses internal frame
      tick(1); gnt = 5'b00001; req_raw = 5'b01001; frame_ext = 1'b0; frame_int = 1'b1;
      tick(20); c = cyc;
      expect_at(c + 1, 5'b01001, 5'b10100, 1, "R5 external idle ignored for internal owner");
      frame_int = 1'b0;
      expect_at(c + 17, 5'b01001, 5'b10101, 1, "R5 internal frame idle counts");
      expect_at(c + 18, 5'b01000, 5'b10101, 1, "R7 internal master blocked");
      tick(19); gnt = 5'b01000; req_raw = 5'b01000; frame_ext = 1'b1; frame_int = 1'b0;
      tick(20); c = cyc;
      expect_at(c + 1, 5'b01000, 5'b10101, 1, "R5 internal idle ignored for external owner");

      // R6: grant change restarts the count
      tick(1); c = cyc; req_raw = 5'b01010; frame_ext = 1'b0;
      tick(10); gnt = 5'b00010;
      expect_at(c + 17, 5'b01010, 5'b10101, 1, "R6 no fault for released owner");
      expect_at(c + 27, 5'b01010, 5'b10101, 1, "R6 count restarted on grant change");
      expect_at(c + 28, 5'b01010, 5'b10111, 1, "R6 fault for new owner");
      expect_at(c + 29, 5'b01000, 5'b10111, 1, "R7 master 1 blocked");
      tick(19); gnt = '0; frame_ext = 1'b1;

      // R6: request drop restarts the count
      tick(1); gnt = 5'b01000; req_raw = 5'b01000;
      tick(2); c = cyc; frame_ext = 1'b0;
      tick(8); req_raw = '0;
      tick(1); req_raw = 5'b01000;
      expect_at(c + 25, 5'b01000, 5'b10111, 1, "R6 request drop restarts count");
      expect_at(c + 26, 5'b01000, 5'b11111, 1, "R6 fault after restart");
      tick(17); gnt = '0; frame_ext = 1'b1;

      // R8: selective clear
      tick(1); c = cyc; req_raw = 5'b11111; clr_stb = 1'b1; clr_sel = 5'b00100;
      expect_at(c + 1, 5'b00000, 5'b11011, 0, "R8 selected flag cleared");
      tick(1); clr_stb = 1'b0; clr_sel = 5'b11111;
      expect_at(c + 2, 5'b00100, 5'b11011, 1, "R8 select without strobe ignored");
      tick(1); clr_stb = 1'b1; clr_sel = 5'b11011;
      expect_at(c + 3, 5'b00000, 5'b00000, 0, "R8 remaining flags cleared");
      tick(1); clr_stb = 1'b0; clr_sel = '0;
      expect_at(c + 4, 5'b11111, 5'b00000, 1, "R8 all requests pass again");

      // R9: several grants never fault
      tick(1); gnt = 5'b00110; req_raw = 5'b00110; frame_ext = 1'b0; irdy_q = 1'b0;
      tick(25); c = cyc;
      expect_at(c + 1, 5'b00110, 5'b00000, 1, "R9 multi-grant never faults");
      tick(3);

      while (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         checks++; failures++;
         $display("FAIL %s: never sampled, actual none expected cycle %0d", e.tag, e.at);
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule